// File: doc/BRIEF.md
# Sticky interrupt status register

This block gathers event indications from an audio receiver into one status byte. The events are a preamble-byte change, a rise of any format-detect flag, an output sample slip, a channel-status buffer transfer, a channel-status change, a receiver error and a subcode block being ready. Each event sets its own status bit, and the bit stays set until software reads the byte. A mask register decides which events can be recorded at all. The block drives a single interrupt line from whatever status is pending.

The read strobe returns the current byte and clears it on the same clock edge. An input selects edge or level recording. In edge mode, a source that stays high is counted once. In level mode, a source that is still true when the read happens keeps its bit set. The event sources are plain input signals. Nothing in this block decodes the audio stream.

Top module: `irq_status_reg`

## Requirements
- R1: After reset the status byte is 0x00, the mask is zero and `irq` sits at its inactive level, which equals `irq_active_low`.
- R2: The bit positions in `rd_data` are fixed. Bit 7 always reads 0. Bit 6 is the preamble change, bit 5 the slip, bit 4 the buffer transfer, bit 3 the channel-status change, bit 2 the receiver error, bit 1 subcode ready and bit 0 the format change.
- R3: Once a status bit is set, it stays 1 until a read or a mask write clears it.
- R4: In edge mode (`level_mode`=0), the clock edge on which `rd_stb` is high clears every bit that has no new event in that cycle. This holds even when the source is still high.
- R5: In level mode (`level_mode`=1), a read does not clear a bit whose enabled source is still true in the read cycle.
- R6: An enabled event that arrives in the same cycle as a read is recorded as set after that read.
- R7: A bit whose mask bit is 0 never sets and reads as 0. Writing 0 to a mask bit through `mask_wr` discards a pending bit in that position.
- R8: Bit 0 sets when any of the five `fmt_flags` goes from 0 to 1. A flag falling from 1 to 0 does not set it.
- R9: Bit 6 sets when `pc_byte` differs from its value in the previous cycle. It also sets when `fmt_flags[1]` (compressed-burst flag) rises, even if `pc_byte` has not changed.
- R10: In edge mode, a source that stays high for several cycles is recorded only on its rising edge. After a read it stays clear while the source remains high.
- R11: `irq` equals `irq_active_low` XOR (any status bit set).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pc_byte | input | 8 | Current burst preamble byte |
| fmt_flags | input | 5 | Format flags: [0] PCM, [1] compressed burst, [2] DTS variant A, [3] DTS variant B, [4] digital silence |
| slip_pulse | input | 1 | Output sample dropped or repeated |
| xfer_busy | input | 1 | High for the whole of a channel-status buffer transfer |
| cs_change_pulse | input | 1 | Channel status differs from the previous block |
| rx_err_pulse | input | 1 | Receiver error detected |
| subcode_rdy_pulse | input | 1 | New subcode block available |
| level_mode | input | 1 | 1 selects level recording, 0 selects edge recording |
| irq_active_low | input | 1 | 1 makes `irq` active low |
| mask_wr | input | 1 | Load `mask_wdata` into the mask register |
| mask_wdata | input | 7 | New mask; bit n enables status bit n |
| rd_stb | input | 1 | Status read; clears the byte at this clock edge |
| rd_data | output | 8 | Status byte |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that every input is a clean synchronous level sampled at the rising edge. They also assume that a mask write and a read never share a cycle, because the mask-related properties are written only for cycles without a mask write. The stimulus changes inputs shortly after each rising edge and keeps `mask_wr` and `rd_stb` in separate cycles. It drives pulse sources for exactly one cycle, except in the steps that deliberately hold the transfer source high to exercise edge and level recording.

// File: rtl/irq_status_reg.sv
module irq_status_reg (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] pc_byte,
  input  logic [4:0] fmt_flags,
  input  logic       slip_pulse,
  input  logic       xfer_busy,
  input  logic       cs_change_pulse,
  input  logic       rx_err_pulse,
  input  logic       subcode_rdy_pulse,
  input  logic       level_mode,
  input  logic       irq_active_low,
  input  logic       mask_wr,
  input  logic [6:0] mask_wdata,
  input  logic       rd_stb,
  output logic [7:0] rd_data,
  output logic       irq
);
  localparam int NB  = 7;
  localparam int CMP = 1;

  logic [7:0]    pc_q;
  logic [4:0]    fmt_q;
  logic [NB-1:0] src, src_q, ev, mask_q, mask_nx, sticky;

  assign src = {(pc_byte != pc_q) | (fmt_flags[CMP] & ~fmt_q[CMP]),
                slip_pulse, xfer_busy, cs_change_pulse, rx_err_pulse,
                subcode_rdy_pulse, |(fmt_flags & ~fmt_q)};

  assign mask_nx = mask_wr ? mask_wdata : mask_q;
  assign ev      = (level_mode ? src : (src & ~src_q)) & mask_nx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q   <= '0;
      fmt_q  <= '0;
      src_q  <= '0;
      mask_q <= '0;
      sticky <= '0;
    end else begin
      pc_q   <= pc_byte;
      fmt_q  <= fmt_flags;
      src_q  <= src;
      mask_q <= mask_nx;
      sticky <= (rd_stb ? ev : (sticky | ev)) & mask_nx;
    end
  end

  assign rd_data = {1'b0, sticky};
  assign irq     = irq_active_low ^ (|sticky);

  a_r3_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_stb && !mask_wr) |=> ((rd_data & $past(rd_data)) == $past(rd_data)));

  a_r4_edge_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && !level_mode && !mask_wr && ev == '0) |=> (rd_data == 8'h00));

  a_r5_level_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && level_mode && !mask_wr && xfer_busy && mask_q[4]) |=> rd_data[4]);

  a_r6_read_race: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && !mask_wr && ev != '0) |=> ((rd_data[6:0] & $past(ev)) == $past(ev)));

  a_r7_mask_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (!mask_wr) |=> ((rd_data[6:0] & ~$past(mask_q)) == '0));

  a_r11_irq_level: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (irq_active_low ^ (rd_data != 8'h00)));
endmodule

// File: tb/tb_irq_status_reg.sv
module tb_irq_status_reg;
  logic clk = 0, rst_n = 0;
  logic [7:0] pc_byte = 0;
  logic [4:0] fmt_flags = 0;
  logic slip_pulse = 0, xfer_busy = 0, cs_change_pulse = 0, rx_err_pulse = 0, subcode_rdy_pulse = 0;
  logic level_mode = 0, irq_active_low = 0, mask_wr = 0, rd_stb = 0;
  logic [6:0] mask_wdata = 0;
  logic [7:0] rd_data;
  logic irq;
  int total = 0, bad = 0;
  bit finished = 0, model_on = 0;

  always #4 clk = ~clk;

  irq_status_reg dut (.*);

  bit [7:0] m_pc;
  bit [4:0] m_fmt;
  bit [6:0] m_srcq, m_mask, m_st;

  always @(posedge clk) begin
    bit [6:0] s, mn;
    bit e;
    if (!rst_n) begin
      m_pc = 0; m_fmt = 0; m_srcq = 0; m_mask = 0; m_st = 0;
    end else begin
      s = 0;
      s[6] = (pc_byte != m_pc) || (fmt_flags[1] && !m_fmt[1]);
      s[5] = slip_pulse; s[4] = xfer_busy; s[3] = cs_change_pulse;
      s[2] = rx_err_pulse; s[1] = subcode_rdy_pulse;
      for (int i = 0; i < 5; i++) if (fmt_flags[i] && !m_fmt[i]) s[0] = 1;
      mn = mask_wr ? mask_wdata : m_mask;
      for (int i = 0; i < 7; i++) begin
        e = mn[i] && s[i] && (level_mode || !m_srcq[i]);
        if (rd_stb) m_st[i] = e;
        else        m_st[i] = (m_st[i] || e) && mn[i];
      end
      m_pc = pc_byte; m_fmt = fmt_flags; m_srcq = s; m_mask = mn;
    end
  end

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (model_on && rst_n && !finished) begin
    chk("R3 model status", rd_data, {1'b0, m_st});
    chk("R11 model irq", {7'b0, irq}, {7'b0, irq_active_low ^ (|m_st)});
  end

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) begin @(posedge clk); #2; end
  endtask

  task automatic do_read;
    rd_stb = 1; tick(); rd_stb = 0;
  endtask

  task automatic set_mask(logic [6:0] m);
    mask_wdata = m; mask_wr = 1; tick(); mask_wr = 0;
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=done");
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    tick(3);
    chk("R1 reset status", rd_data, 8'h00);
    chk("R1 reset irq", {7'b0, irq}, 8'h00);
    rst_n = 1; model_on = 1;
    tick();
    chk("R7 zero mask blocks", rd_data, 8'h00);
    rx_err_pulse = 1; tick(); rx_err_pulse = 0;
    chk("R7 masked event ignored", rd_data, 8'h00);
    set_mask(7'h7F);

    rx_err_pulse = 1; tick(); rx_err_pulse = 0;
    chk("R2 error bit position", rd_data, 8'h04);
    chk("R11 irq high", {7'b0, irq}, 8'h01);
    tick(3);
    chk("R3 bit held", rd_data, 8'h04);
    rd_stb = 1;
    chk("R4 read value", rd_data, 8'h04);
    tick(); rd_stb = 0;
    chk("R4 cleared by read", rd_data, 8'h00);

    fmt_flags = 5'b00001; tick();
    chk("R8 rising flag", rd_data, 8'h01);
    do_read();
    fmt_flags = 5'b00000; tick();
    chk("R8 falling flag ignored", rd_data, 8'h00);
    fmt_flags = 5'b10000; tick(); fmt_flags = 5'b10100; tick();
    chk("R8 later flag rise", rd_data, 8'h01);
    fmt_flags = 0; do_read();

    pc_byte = 8'h15; tick();
    chk("R9 preamble byte change", rd_data, 8'h40);
    do_read();
    fmt_flags = 5'b00010; tick();
    chk("R9 compressed rise forces", rd_data, 8'h41);
    do_read();
    fmt_flags = 0; tick(); fmt_flags = 5'b00010; tick();
    chk("R9 second rise same byte", rd_data, 8'h41);
    fmt_flags = 0; do_read();

    xfer_busy = 1; tick();
    chk("R2 transfer bit position", rd_data, 8'h10);
    tick(2); do_read();
    chk("R10 held source cleared", rd_data, 8'h00);
    tick(3);
    chk("R10 no re-record while held", rd_data, 8'h00);
    xfer_busy = 0; tick();

    level_mode = 1; xfer_busy = 1; tick();
    chk("R5 level record", rd_data, 8'h10);
    do_read();
    chk("R5 kept while source true", rd_data, 8'h10);
    xfer_busy = 0; do_read();
    chk("R5 cleared after release", rd_data, 8'h00);
    level_mode = 0; tick();

    rx_err_pulse = 1; tick(); rx_err_pulse = 0;
    rd_stb = 1; subcode_rdy_pulse = 1; tick(); rd_stb = 0; subcode_rdy_pulse = 0;
    chk("R6 event during read kept", rd_data, 8'h02);
    do_read();

    slip_pulse = 1; cs_change_pulse = 1; tick(); slip_pulse = 0; cs_change_pulse = 0;
    chk("R2 slip and cs bits", rd_data, 8'h28);
    do_read();

    set_mask(7'h7B);
    rx_err_pulse = 1; tick(); rx_err_pulse = 0;
    chk("R7 disabled bit reads zero", rd_data, 8'h00);
    chk("R7 no irq", {7'b0, irq}, 8'h00);
    set_mask(7'h7F);
    rx_err_pulse = 1; tick(); rx_err_pulse = 0;
    chk("R7 re-enabled sets", rd_data, 8'h04);
    set_mask(7'h7B);
    chk("R7 mask write discards", rd_data, 8'h00);

    irq_active_low = 1; tick();
    chk("R11 active low idle", {7'b0, irq}, 8'h01);
    subcode_rdy_pulse = 1; tick(); subcode_rdy_pulse = 0;
    chk("R11 active low asserted", {7'b0, irq}, 8'h00);
    do_read();
    chk("R11 active low released", {7'b0, irq}, 8'h01);

    tick(2);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule